// File: doc/BRIEF.md
# Chiplet Boot Reauthentication Controller

This block runs the per-chiplet identity check at secure boot. It steps through the chiplets one at a time by index. For each one it asks an external hash engine for that chiplet's authentication digest, and waits for the answer or for a timeout.

On the very first boot the one-time-programmable (OTP) store is still unlocked. In that case the block writes each fresh digest into the OTP word for that chiplet. It enables the chiplet without comparing anything, and it sets the OTP lock once the pass is over. On every later boot the OTP is locked. The block then compares each fresh digest with the stored word. It enables only the chiplets whose digests match and flags the rest in a mismatch bitmap.

Enable outputs stay dark for the whole session and are released together when the session ends, alongside a one-cycle done pulse. A request to enroll a second time is refused and does not touch the store.

Top module: `boot_reauth_ctrl`

## Requirements
- R1: After reset, chip_en and mismatch are all zero, done is low, status is 0 (idle), and hash_req and otp_we are low.
- R2: A session started while otp_locked is 0 enrolls. For each chiplet, the returned digest is written with otp_we at otp_addr equal to the chiplet index. The chiplet then counts as passing without any comparison. otp_lock_set pulses once at the end.
- R3: Chiplets are visited in index order 0 up to N_CHIP-1. For each one, hash_req is a single-cycle pulse carrying its index on hash_idx.
- R4: A session started while otp_locked is 1 verifies. A chiplet whose returned digest equals otp_rdata for its index gets its chip_en bit set.
- R5: A chiplet whose digest differs from the stored word gets its chip_en bit cleared and its mismatch bit set. Other chiplets are not affected.
- R6: If hash_vld does not arrive within 2*HASH_LAT cycles of a request, that chiplet is treated as a mismatch and the sequence moves on.
- R7: While a session runs, status is 1 and chip_en is all zero. chip_en takes its final value in the same cycle that done pulses.
- R8: done is a single-cycle pulse. When a session completes, status becomes 2; the mismatch bitmap then says which chiplets failed.
- R9: enroll_req while otp_locked is 1 is rejected. done pulses, status becomes 3, and no hash request or OTP write is issued. chip_en and mismatch keep their values.
- R10: otp_we is never asserted while otp_locked is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a boot session; the mode follows otp_locked |
| enroll_req | input | 1 | Explicit enrollment request; rejected when the OTP is locked |
| hash_req | output | 1 | Digest request pulse to the hash engine |
| hash_idx | output | IDX_W | Chiplet index for the request |
| hash_vld | input | 1 | Digest valid from the hash engine |
| hash_dig | input | DIG_W | Returned digest |
| otp_addr | output | IDX_W | OTP word index, equal to the current chiplet |
| otp_rdata | input | DIG_W | Stored digest at otp_addr |
| otp_we | output | 1 | OTP program strobe |
| otp_wdata | output | DIG_W | Digest to program |
| otp_lock_set | output | 1 | Pulse that locks the OTP after enrollment |
| otp_locked | input | 1 | OTP already programmed and locked |
| chip_en | output | N_CHIP | Per-chiplet enable |
| mismatch | output | N_CHIP | Per-chiplet failure bitmap |
| done | output | 1 | End-of-session pulse |
| status | output | 2 | 0 idle, 1 busy, 2 complete, 3 rejected |

## Verification
The hardest case to reach is a timeout in the middle of a sequence. Here the hash engine stays silent for one chiplet while its neighbours answer, and the sequence must still finish with only that chiplet flagged. The bench's engine model has a per-index mute switch, so a verify session can be run with one index silent. The bench then checks both the resulting bitmap and that the session took at least the full timeout window. The refused second enrollment is reached by issuing enroll_req right after a completed enrollment. The bench counts hash requests and OTP writes around it to show that nothing moved.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_DONE   = 2'd2,
    ST_REJECT = 2'd3
  } brc_status_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2,
    F_FIN  = 2'd3
  } brc_fsm_e;

  // one verdict for a chiplet: passing when enrolling or when digests agree
  function automatic logic chip_pass(input logic enrolling, input logic digests_equal);
    return enrolling | digests_equal;
  endfunction
endpackage

// File: rtl/brc_timer.sv
module brc_timer #(
  parameter int LIMIT = 192,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/brc_cmp.sv
module brc_cmp #(
  parameter int DIG_W   = 256,
  parameter int SLICE_W = 32,
  localparam int NSL = DIG_W / SLICE_W
) (
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  output logic             eq
);
  logic [NSL-1:0] slice_eq;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    assign slice_eq[s] = (a[s*SLICE_W +: SLICE_W] == b[s*SLICE_W +: SLICE_W]);
  end

  assign eq = &slice_eq;
endmodule

// File: rtl/boot_reauth_ctrl.sv
module boot_reauth_ctrl #(
  parameter int N_CHIP   = 4,
  parameter int DIG_W    = 256,
  parameter int HASH_LAT = 96,
  localparam int IDX_W = (N_CHIP > 1) ? $clog2(N_CHIP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              enroll_req,
  output logic              hash_req,
  output logic [IDX_W-1:0]  hash_idx,
  input  logic              hash_vld,
  input  logic [DIG_W-1:0]  hash_dig,
  output logic [IDX_W-1:0]  otp_addr,
  input  logic [DIG_W-1:0]  otp_rdata,
  output logic              otp_we,
  output logic [DIG_W-1:0]  otp_wdata,
  output logic              otp_lock_set,
  input  logic              otp_locked,
  output logic [N_CHIP-1:0] chip_en,
  output logic [N_CHIP-1:0] mismatch,
  output logic              done,
  output logic [1:0]        status
);
  import brc_pkg::*;

  localparam int TMO_CYC = 2 * HASH_LAT;

  brc_fsm_e          fsm_q;
  brc_status_e       status_q;
  logic [IDX_W-1:0]  idx_q;
  logic              enroll_q;
  logic [N_CHIP-1:0] pass_q, en_q, mm_q;
  logic              done_q, lock_q;

  // named internal events
  logic in_wait, tmo_hit, cmp_eq, got_dig, last_chip, kick, refuse;

  assign in_wait   = (fsm_q == F_WAIT);
  assign got_dig   = in_wait && hash_vld;
  assign last_chip = (idx_q == IDX_W'(N_CHIP - 1));
  assign kick      = (fsm_q == F_IDLE) && (start || enroll_req);
  assign refuse    = kick && enroll_req && otp_locked;

  brc_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fsm_q == F_REQ),
    .run     (in_wait && !hash_vld),
    .expired (tmo_hit)
  );

  brc_cmp #(.DIG_W(DIG_W)) u_cmp (
    .a  (hash_dig),
    .b  (otp_rdata),
    .eq (cmp_eq)
  );

  assign hash_req     = (fsm_q == F_REQ);
  assign hash_idx     = idx_q;
  assign otp_addr     = idx_q;
  assign otp_we       = got_dig && enroll_q && !otp_locked;
  assign otp_wdata    = hash_dig;
  assign otp_lock_set = lock_q;
  assign chip_en      = en_q;
  assign mismatch     = mm_q;
  assign done         = done_q;
  assign status       = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q    <= F_IDLE;
      status_q <= ST_IDLE;
      idx_q    <= '0;
      enroll_q <= 1'b0;
      pass_q   <= '0;
      en_q     <= '0;
      mm_q     <= '0;
      done_q   <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      lock_q <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (refuse) begin
            status_q <= ST_REJECT;
            done_q   <= 1'b1;
          end else if (kick) begin
            enroll_q <= !otp_locked;
            idx_q    <= '0;
            pass_q   <= '0;
            en_q     <= '0;
            mm_q     <= '0;
            status_q <= ST_BUSY;
            fsm_q    <= F_REQ;
          end
        end
        F_REQ: fsm_q <= F_WAIT;
        F_WAIT: begin
          if (got_dig || tmo_hit) begin
            if (got_dig && chip_pass(enroll_q, cmp_eq)) pass_q[idx_q] <= 1'b1;
            else                                        mm_q[idx_q]   <= 1'b1;
            if (last_chip) fsm_q <= F_FIN;
            else begin
              idx_q <= idx_q + 1'b1;
              fsm_q <= F_REQ;
            end
          end
        end
        F_FIN: begin
          en_q     <= pass_q;
          done_q   <= 1'b1;
          lock_q   <= enroll_q;
          status_q <= ST_DONE;
          fsm_q    <= F_IDLE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int N_CHIP = 4,
  localparam int IDX_W = (N_CHIP > 1) ? $clog2(N_CHIP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hash_req,
  input logic              hash_vld,
  input logic              otp_we,
  input logic              otp_locked,
  input logic [N_CHIP-1:0] chip_en,
  input logic [N_CHIP-1:0] mismatch,
  input logic              done,
  input logic [1:0]        status,
  input logic              tmo_hit,
  input logic [IDX_W-1:0]  idx_q
);
  // R3: one request pulse per chiplet
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req |=> !hash_req);

  // R6: a timeout marks the current chiplet as failed
  a_r6_tmo_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> mismatch[$past(idx_q)]);

  // R7: enables are dark while a session runs
  a_r7_dark_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |-> (chip_en == '0));

  // R5: no chiplet is both enabled and flagged
  a_r5_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((chip_en & mismatch) == '0));

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a locked store is never programmed
  a_r10_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    otp_we |-> !otp_locked);

  // R2: programming only happens on a delivered digest
  a_r2_write_on_digest: assert property (@(posedge clk) disable iff (!rst_n)
    otp_we |-> hash_vld);
endmodule

bind boot_reauth_ctrl brc_checker #(.N_CHIP(N_CHIP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hash_req   (hash_req),
  .hash_vld   (hash_vld),
  .otp_we     (otp_we),
  .otp_locked (otp_locked),
  .chip_en    (chip_en),
  .mismatch   (mismatch),
  .done       (done),
  .status     (status),
  .tmo_hit    (tmo_hit),
  .idx_q      (idx_q)
);

// File: tb/boot_reauth_ctrl_tb.sv
module boot_reauth_ctrl_tb;
  localparam int N   = 4;
  localparam int DW  = 256;
  localparam int LAT = 96;
  localparam int IW  = 2;

  typedef struct packed {
    logic [N-1:0] en;
    logic [N-1:0] mm;
    logic [1:0]   st;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, enroll_req = 0;
  logic hash_req, hash_vld = 0;
  logic [IW-1:0] hash_idx, otp_addr;
  logic [DW-1:0] hash_dig = '0, otp_wdata;
  logic otp_we, otp_lock_set, done;
  logic otp_locked = 0;
  logic [N-1:0] chip_en, mismatch;
  logic [1:0] status;

  logic [DW-1:0] otp_mem [N];
  logic [DW-1:0] live_dig [N];
  logic [N-1:0]  mute = '0;
  int total = 0, bad = 0, cyc = 0;
  int req_cnt = 0, wr_cnt = 0, exp_idx = 0, done_cyc = 0;
  int pend_cnt = 0;
  logic [IW-1:0] pend_idx = '0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  boot_reauth_ctrl #(.N_CHIP(N), .DIG_W(DW), .HASH_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .enroll_req(enroll_req),
    .hash_req(hash_req), .hash_idx(hash_idx), .hash_vld(hash_vld), .hash_dig(hash_dig),
    .otp_addr(otp_addr), .otp_rdata(otp_mem[otp_addr]), .otp_we(otp_we),
    .otp_wdata(otp_wdata), .otp_lock_set(otp_lock_set), .otp_locked(otp_locked),
    .chip_en(chip_en), .mismatch(mismatch), .done(done), .status(status)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // hash engine and OTP models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    hash_vld <= 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        hash_vld <= 1'b1;
        hash_dig <= live_dig[pend_idx];
      end
    end
    if (hash_req && !mute[hash_idx]) begin
      pend_cnt <= LAT;
      pend_idx <= hash_idx;
    end
    if (otp_we && !otp_locked) otp_mem[otp_addr] <= otp_wdata;
    if (otp_lock_set) otp_locked <= 1'b1;
  end

  // request order (R3) and locked-write (R10) monitor
  always @(negedge clk) begin
    if (rst_n && hash_req) begin
      req_cnt++;
      chk(hash_idx == IW'(exp_idx), "R3 request order", hash_idx, exp_idx);
      exp_idx = (exp_idx + 1) % N;
    end
    if (rst_n && otp_we) begin
      wr_cnt++;
      chk(!otp_locked, "R10 write while locked", otp_locked, 0);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cyc = cyc;
      if (sb_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(chip_en == e.en, "R4/R5 chip_en", chip_en, e.en);
        chk(mismatch == e.mm, "R5/R6 mismatch", mismatch, e.mm);
        chk(status == e.st, "R8/R9 status", status, e.st);
      end
    end
  end

  task automatic run_session(input bit enr, input exp_t e);
    sb_q.push_back(e);
    @(negedge clk);
    if (enr) enroll_req = 1; else start = 1;
    @(negedge clk);
    start = 0;
    enroll_req = 0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  initial begin
    int t0, rq0, wr0;
    for (int i = 0; i < N; i++) begin
      otp_mem[i]  = '0;
      live_dig[i] = {8{32'hC0DE_0000 + 32'(i * 17)}};
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(chip_en == '0 && mismatch == '0, "R1 reset outputs", {chip_en, mismatch}, 0);
    chk(done == 0 && status == 2'd0, "R1 reset status", {done, status}, 0);
    chk(hash_req == 0 && otp_we == 0, "R1 reset strobes", {hash_req, otp_we}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 enrollment
    run_session(0, '{en: 4'b1111, mm: 4'b0000, st: 2'd2});
    @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(otp_mem[i] == live_dig[i], "R2 OTP word programmed", otp_mem[i], live_dig[i]);
    chk(otp_locked == 1'b1, "R2 lock set", otp_locked, 1);

    // R9 second enrollment refused
    rq0 = req_cnt; wr0 = wr_cnt;
    run_session(1, '{en: 4'b1111, mm: 4'b0000, st: 2'd3});
    chk(req_cnt == rq0, "R9 no hash request", req_cnt, rq0);
    chk(wr_cnt == wr0, "R9 no OTP write", wr_cnt, wr0);

    // R4 verify, all match; R7 dark while busy
    sb_q.push_back('{en: 4'b1111, mm: 4'b0000, st: 2'd2});
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (50) @(negedge clk);
    chk(chip_en == '0, "R7 enables dark while busy", chip_en, 0);
    chk(status == 2'd1, "R7 status busy", status, 1);
    while (sb_q.size() != 0) @(negedge clk);
    chk(wr_cnt == wr0, "R10 verify leaves OTP alone", wr_cnt, wr0);

    // R5 single mismatch
    live_dig[1] = ~live_dig[1];
    run_session(0, '{en: 4'b1101, mm: 4'b0010, st: 2'd2});
    // R5 several mismatches
    live_dig[0] = live_dig[0] ^ 256'h1;
    live_dig[3] = live_dig[3] ^ {1'b1, 255'h0};
    run_session(0, '{en: 4'b0100, mm: 4'b1011, st: 2'd2});
    for (int i = 0; i < N; i++) live_dig[i] = otp_mem[i];

    // R6 timeout on chiplet 2
    mute[2] = 1'b1;
    t0 = cyc;
    run_session(0, '{en: 4'b1011, mm: 4'b0100, st: 2'd2});
    chk(done_cyc - t0 >= 2 * LAT, "R6 waited full timeout", done_cyc - t0, 2 * LAT);
    mute = '0;

    // R4 recovery after restoring
    run_session(0, '{en: 4'b1111, mm: 4'b0000, st: 2'd2});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule